// File: doc/BRIEF.md
# Stream Tracking Region Prefetcher

This block sits beside a second-level cache and watches its demand traffic. It keeps a small table of tracking entries. A demand miss that no entry claims seeds a new entry. The next two misses that land within a short reach of that seed line teach the entry which way the stream runs. Once the direction is learned, the entry guards a window of lines. Any demand access inside that window, hit or miss, makes the entry ask for the next few lines past the window's leading edge. The window then slides forward by the same count.

Each access is presented as one line address, a valid strobe and a miss flag. Prefetch line addresses leave on a valid/ready stream, one per cycle. Each entry holds its own burst of pending requests. An entry does not react to a new trigger until its own burst has fully left the block.

Top module: `stream_prefetcher`

## Requirements
- R1: After synchronous active-low reset, `pf_valid` is low and every tracking entry is free, so no access can produce a prefetch until a stream has been seeded and trained again.
- R2: A miss that no entry claims seeds an entry at that line. Hits (`dmd_miss` = 0) never seed or train an entry.
- R3: While an entry is learning, it claims accesses whose line differs from the seed line by 0 to 16 lines in either direction. Only claimed misses at a non-zero offset count as training misses. A miss 17 lines away is not claimed.
- R4: If two training misses both lie above the seed, the entry becomes ascending. If both lie below, it becomes descending. In either case it starts guarding the window whose start A is the seed and whose end P is A+2 (ascending) or A-2 (descending).
- R5: If the two training misses lie on opposite sides of the seed, the entry is freed. Later accesses near the old seed then trigger nothing.
- R6: A demand access (hit or miss) to any line between A and P inclusive makes a guarding entry request P+1 then P+2 when ascending, or P-1 then P-2 when descending.
- R7: After a trigger, both A and P move by 2 lines in the stream direction. Lines that have fallen behind the new A no longer trigger.
- R8: Requests leave at most one per cycle. While `pf_ready` is low, `pf_valid` stays high and `pf_line` holds its value.
- R9: While an entry still has requests waiting to leave, further accesses inside its window are ignored. They do not add requests and they do not move the window.
- R10: Seeding uses the lowest-numbered free entry. When no entry is free, it replaces entries in turn, starting at entry 0 and wrapping after entry 7. A replaced entry loses its window and any waiting requests.
- R11: When several entries could claim an access, only the lowest-numbered one acts on it.
- R12: The span between A and P of a guarding entry never exceeds the prefetch distance of 16 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dmd_valid | input | 1 | A demand access is presented this cycle |
| dmd_line | input | 32 | Line address of the demand access |
| dmd_miss | input | 1 | 1 when the access missed the cache |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_line | output | 32 | Offered prefetch line address |
| pf_ready | input | 1 | Consumer accepts the offered address this cycle |

## Verification
A wrong direction bit or a wrong window edge shows up at `pf_line` on the first trigger after training. The bad address appears one cycle after the triggering access, and the second address one cycle later. A stale busy count or a window that failed to slide is seen on the next access inside the window: requests either fail to appear or appear twice. A replacement pointer that advances wrongly leaves the wrong stream alive. This is caught when an access to the supposedly evicted window produces prefetches, or an access to a surviving window produces none. The bench sweeps every training offset from -17 to +17 lines, with the expected prefetch lines computed from the seed address.

// File: rtl/stp_pkg.sv
// Shared types for the stream tracking prefetcher.
package stp_pkg;
    // Lifecycle of one tracking entry.
    typedef enum logic [1:0] {
        TRK_FREE   = 2'd0,
        TRK_SEEDED = 2'd1,
        TRK_LEARN  = 2'd2,
        TRK_GUARD  = 2'd3
    } trk_state_e;
endpackage

// File: rtl/stp_track_entry.sv
// One tracking entry: seeds on a miss, learns direction from two nearby
// misses, then guards a window [A,P] and loads a burst of DEGREE requests
// when an access lands inside it.
// Assumes: claim_i and seed_i are never high together; pop_i only while
// pend_o is high.
module stp_track_entry #(
    parameter int ADDR_W    = 32,
    parameter int DEGREE    = 2,
    parameter int DIST      = 16,
    parameter int TRAIN_WIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_line,
    input  logic              acc_miss,
    input  logic              claim_i,
    input  logic              seed_i,
    input  logic              pop_i,
    output logic              match_o,
    output logic              free_o,
    output logic              pend_o,
    output logic [ADDR_W-1:0] req_line_o
);
    import stp_pkg::*;

    localparam int              CNT_W = $clog2(DEGREE + 1);
    localparam logic [ADDR_W-1:0] DEG_A = ADDR_W'(DEGREE);
    localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(TRAIN_WIN);
    localparam logic [ADDR_W-1:0] DST_A = ADDR_W'(DIST);

    trk_state_e        state_q;
    logic [ADDR_W-1:0] start_q;   // A: seed line, later window start
    logic [ADDR_W-1:0] end_q;     // P: leading window edge
    logic              up_q;      // 1 = ascending
    logic [CNT_W-1:0]  cnt_q;     // requests still to leave
    logic [ADDR_W-1:0] next_q;    // next request line

    logic [ADDR_W-1:0] off, span, pos;
    logic              near_up, near_dn, in_win;

    // Offsets of the access relative to the seed and to the window.
    always_comb begin
        off     = acc_line - start_q;
        near_up = (off != '0) && (off <= WIN_A);
        near_dn = (off != '0) && ((-off) <= WIN_A);
        span    = up_q ? (end_q - start_q) : (start_q - end_q);
        pos     = up_q ? (acc_line - start_q) : (start_q - acc_line);
        in_win  = (pos <= span);
    end

    // Claim test for the current access.
    always_comb begin
        unique case (state_q)
            TRK_SEEDED, TRK_LEARN: match_o = acc_valid && (near_up || near_dn || off == '0);
            TRK_GUARD:             match_o = acc_valid && in_win;
            default:               match_o = 1'b0;
        endcase
    end

    assign free_o     = (state_q == TRK_FREE);
    assign pend_o     = (cnt_q != '0);
    assign req_line_o = next_q;

    // Entry state, window and burst bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_FREE;
            start_q <= '0;
            end_q   <= '0;
            up_q    <= 1'b0;
            cnt_q   <= '0;
            next_q  <= '0;
        end else if (seed_i) begin
            state_q <= TRK_SEEDED;
            start_q <= acc_line;
            cnt_q   <= '0;
        end else begin
            if (pop_i) begin
                cnt_q  <= cnt_q - 1'b1;
                next_q <= up_q ? next_q + 1'b1 : next_q - 1'b1;
            end
            if (claim_i) begin
                unique case (state_q)
                    TRK_SEEDED: if (acc_miss && off != '0) begin
                        up_q    <= near_up;
                        state_q <= TRK_LEARN;
                    end
                    TRK_LEARN: if (acc_miss && off != '0) begin
                        if (near_up == up_q) begin
                            state_q <= TRK_GUARD;
                            end_q   <= up_q ? start_q + DEG_A : start_q - DEG_A;
                        end else begin
                            state_q <= TRK_FREE;
                        end
                    end
                    TRK_GUARD: if (cnt_q == '0) begin
                        next_q  <= up_q ? end_q + 1'b1 : end_q - 1'b1;
                        cnt_q   <= CNT_W'(DEGREE);
                        start_q <= up_q ? start_q + DEG_A : start_q - DEG_A;
                        end_q   <= up_q ? end_q + DEG_A : end_q - DEG_A;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_i |=> state_q == TRK_SEEDED);
    p_disagree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && !seed_i && acc_miss && state_q == TRK_LEARN && off != '0 && near_up != up_q)
        |=> state_q == TRK_FREE);
    p_burst_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEGREE));
    p_pend_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> state_q == TRK_GUARD);
    p_pop_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> cnt_q != '0);
    p_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_GUARD) |-> span <= DST_A);
endmodule

// File: rtl/stp_victim.sv
// Chooses the entry to seed: lowest free entry, otherwise a rotating
// replacement pointer that starts at entry 0.
// Assumes: need_i is high only for an unclaimed demand miss.
module stp_victim #(
    parameter int NUM_ENT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               need_i,
    input  logic [NUM_ENT-1:0] free_i,
    output logic [NUM_ENT-1:0] seed_o
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic [IDX_W-1:0]   rr_q;
    logic [NUM_ENT-1:0] low_free;

    // Lowest-numbered free entry as a one-hot vector.
    always_comb begin
        low_free = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                low_free    = '0;
                low_free[i] = 1'b1;
            end
        end
    end

    // Seed vector: free entry first, rotating replacement otherwise.
    always_comb begin
        seed_o = '0;
        if (need_i) begin
            if (|free_i) seed_o = low_free;
            else         seed_o[rr_q] = 1'b1;
        end
    end

    // Replacement pointer advances only when it was used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (need_i && !(|free_i)) begin
            rr_q <= (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    p_seed_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        need_i |-> $onehot(seed_o));
    p_seed_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (need_i && |free_i) |-> $onehot(seed_o & free_i));
endmodule

// File: rtl/stp_issue.sv
// Drains pending bursts to the prefetch stream, one line per cycle.
// Once an offer has been stalled, the same entry stays selected until it
// is accepted or the entry is replaced.
module stp_issue #(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_ENT-1:0]              pend_i,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0]  line_i,
    input  logic [NUM_ENT-1:0]              drop_i,
    input  logic                            ready_i,
    output logic                            valid_o,
    output logic [ADDR_W-1:0]               line_o,
    output logic [NUM_ENT-1:0]              pop_o
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic             lock_q;
    logic [IDX_W-1:0] lock_idx_q;
    logic [IDX_W-1:0] low_idx, sel;

    // Lowest pending entry.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (pend_i[i]) low_idx = IDX_W'(i);
        end
    end

    // Keep a stalled owner, otherwise take the lowest pending one.
    always_comb begin
        sel = (lock_q && pend_i[lock_idx_q]) ? lock_idx_q : low_idx;
        valid_o = |pend_i;
        line_o  = line_i[sel];
        pop_o   = '0;
        if (valid_o && ready_i) pop_o[sel] = 1'b1;
    end

    // Remember a stalled owner for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_q     <= valid_o && !ready_i && !drop_i[sel];
            lock_idx_q <= sel;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !drop_i[sel]) |=> (valid_o && $stable(line_o)));
    p_one_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_o));
endmodule

// File: rtl/stream_prefetcher.sv
// Top: table of tracking entries, claim priority, seeding and the
// prefetch output stream.
// Assumes: one demand access per cycle at most.
module stream_prefetcher #(
    parameter int NUM_ENT   = 8,
    parameter int ADDR_W    = 32,
    parameter int DEGREE    = 2,
    parameter int DIST      = 16,
    parameter int TRAIN_WIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic [ADDR_W-1:0] dmd_line,
    input  logic              dmd_miss,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_line,
    input  logic              pf_ready
);
    logic [NUM_ENT-1:0]             match_vec, claim_vec, free_vec;
    logic [NUM_ENT-1:0]             seed_vec, pend_vec, pop_vec;
    logic [NUM_ENT-1:0][ADDR_W-1:0] req_vec;
    logic                           need_seed;

    // Lowest-numbered matching entry wins the access.
    always_comb begin
        claim_vec = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                claim_vec    = '0;
                claim_vec[i] = 1'b1;
            end
        end
    end

    assign need_seed = dmd_valid && dmd_miss && !(|match_vec);

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        stp_track_entry #(
            .ADDR_W(ADDR_W), .DEGREE(DEGREE), .DIST(DIST), .TRAIN_WIN(TRAIN_WIN)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_valid  (dmd_valid),
            .acc_line   (dmd_line),
            .acc_miss   (dmd_miss),
            .claim_i    (claim_vec[g]),
            .seed_i     (seed_vec[g]),
            .pop_i      (pop_vec[g]),
            .match_o    (match_vec[g]),
            .free_o     (free_vec[g]),
            .pend_o     (pend_vec[g]),
            .req_line_o (req_vec[g])
        );
    end

    stp_victim #(.NUM_ENT(NUM_ENT)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .need_i (need_seed),
        .free_i (free_vec),
        .seed_o (seed_vec)
    );

    stp_issue #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_vec),
        .line_i  (req_vec),
        .drop_i  (seed_vec),
        .ready_i (pf_ready),
        .valid_o (pf_valid),
        .line_o  (pf_line),
        .pop_o   (pop_vec)
    );

    p_claim_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));
    p_claim_or_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_vec) |-> !(|seed_vec));
    p_hit_no_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_valid && !dmd_miss) |-> !(|seed_vec));
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);
endmodule

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmd_valid = 1'b0;
    logic [31:0] dmd_line = '0;
    logic        dmd_miss = 1'b0;
    logic        pf_valid;
    logic [31:0] pf_line;
    logic        pf_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    logic [31:0] cap[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stream_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
        .dmd_miss(dmd_miss), .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready)
    );

    // Record every accepted prefetch line.
    always @(posedge clk) begin
        if (rst_n && pf_valid && pf_ready) cap.push_back(pf_line);
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dmd_valid = 1'b0; pf_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cap.delete();
    endtask

    task automatic access(input logic [31:0] ln, input logic miss);
        @(negedge clk);
        dmd_valid = 1'b1; dmd_line = ln; dmd_miss = miss;
        @(negedge clk);
        dmd_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_out(input string tag, input int n, input logic [31:0] e0, input logic [31:0] e1);
        logic ok;
        logic [31:0] g0, g1;
        g0 = (cap.size() > 0) ? cap[0] : 32'h0;
        g1 = (cap.size() > 1) ? cap[1] : 32'h0;
        ok = (cap.size() == n);
        if (ok && n >= 1) ok = (g0 == e0);
        if (ok && n >= 2) ok = (g1 == e1);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d lines (%h %h) expected %0d lines (%h %h)",
                     tag, cap.size(), g0, g1, n, e0, e1);
        end
        cap.delete();
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] base, p;

        // R1: idle after reset; R2: hits do not seed.
        do_reset();
        check_bit("R1 pf_valid after reset", pf_valid, 1'b0);
        access(32'd700, 1'b0); access(32'd701, 1'b0); access(32'd702, 1'b0); access(32'd700, 1'b0);
        settle();
        check_out("R2 hits never train", 0, 0, 0);

        // R4/R6/R7: ascending stream, A=1000, P=1002.
        do_reset();
        access(32'd1000, 1'b1); access(32'd1003, 1'b1); access(32'd1005, 1'b1);
        settle();
        check_out("R4 no output from training", 0, 0, 0);
        access(32'd1001, 1'b0); settle();
        check_out("R6 ascending burst", 2, 32'd1003, 32'd1004);
        access(32'd1001, 1'b0); settle();
        check_out("R7 line behind new start", 0, 0, 0);
        access(32'd1004, 1'b0); settle();
        check_out("R7 shifted window edge", 2, 32'd1005, 32'd1006);

        // R4/R6/R7: descending stream, A=5000, P=4998.
        do_reset();
        access(32'd5000, 1'b1); access(32'd4990, 1'b1); access(32'd4984, 1'b1);
        access(32'd4999, 1'b0); settle();
        check_out("R6 descending burst", 2, 32'd4997, 32'd4996);
        access(32'd4996, 1'b1); settle();
        check_out("R7 descending shift", 2, 32'd4995, 32'd4994);

        // R5: disagreeing training frees the entry.
        do_reset();
        access(32'd2000, 1'b1); access(32'd2005, 1'b1); access(32'd1995, 1'b1);
        access(32'd2000, 1'b0); access(32'd2001, 1'b0); settle();
        check_out("R5 freed after disagreement", 0, 0, 0);

        // R3/R11: reach boundary and lowest-entry priority.
        do_reset();
        access(32'd3000, 1'b1); access(32'd3017, 1'b1); access(32'd3016, 1'b1); access(32'd3010, 1'b1);
        access(32'd3002, 1'b0); settle();
        check_out("R11 lowest entry trains on shared miss", 2, 32'd3003, 32'd3004);

        // R8/R9: backpressure and busy entry.
        do_reset();
        access(32'd100, 1'b1); access(32'd101, 1'b1); access(32'd102, 1'b1);
        pf_ready = 1'b0;
        access(32'd100, 1'b0);
        for (int k = 0; k < 3; k++) begin
            check_bit("R8 valid held under stall", pf_valid, 1'b1);
            check_word("R8 line held under stall", pf_line, 32'd103);
            @(negedge clk);
        end
        access(32'd103, 1'b0);
        pf_ready = 1'b1;
        settle();
        check_out("R9 busy entry ignores trigger", 2, 32'd103, 32'd104);
        access(32'd103, 1'b0); settle();
        check_out("R9 window moved only once", 2, 32'd105, 32'd106);

        // R10: lowest free seeding, then rotating replacement.
        do_reset();
        access(32'h1000, 1'b1); access(32'h1001, 1'b1); access(32'h1002, 1'b1);
        for (int k = 2; k <= 8; k++) access(32'h1000 * k, 1'b1);
        access(32'h3001, 1'b1); access(32'h3002, 1'b1);
        access(32'h9000, 1'b1); access(32'hA000, 1'b1);
        access(32'h1001, 1'b0); settle();
        check_out("R10 entry 0 replaced first", 0, 0, 0);
        access(32'h3001, 1'b0); settle();
        check_out("R10 entry 2 survives two replacements", 2, 32'h3003, 32'h3004);
        access(32'hB000, 1'b1);
        access(32'h3003, 1'b0); settle();
        check_out("R10 entry 2 replaced third", 0, 0, 0);

        // R3/R4/R12 sweep over every training offset from -17 to +17.
        for (int d = -17; d <= 17; d++) begin
            if (d != 0) begin
                do_reset();
                base = 32'h4000;
                access(base, 1'b1);
                access(base + 32'(d), 1'b1);
                access(base + 32'(d), 1'b1);
                access(base, 1'b0);
                settle();
                if (d > 16 || d < -16) begin
                    check_out("R3 offset beyond reach", 0, 0, 0);
                end else if (d > 0) begin
                    p = base + 32'd2;
                    check_out("R3 R4 R12 ascending offset", 2, p + 32'd1, p + 32'd2);
                end else begin
                    p = base - 32'd2;
                    check_out("R3 R4 R12 descending offset", 2, p - 32'd1, p - 32'd2);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule